// File: doc/BRIEF.md
# Phase Accumulator With Delayed Offset and Tuning Updates

This block is the numeric heart of a direct digital synthesizer. A 32-bit accumulator advances by the active tuning word on every system clock edge, so the output frequency is the tuning word times the system clock rate divided by 2^32. For example, a word of 0x0E38E38E at 180 MHz gives close to 10 MHz. A 5-bit phase offset is added to the five most significant accumulator bits. The upper 14 bits of that sum are registered and passed to a sine lookup stage that lies outside this block.

New tuning and offset values come from a control register in another clock domain. They are committed by an update strobe. The strobe is brought into the system clock domain through two flops, and its rising edge is then detected. The values are captured and travel through two separate delay lines, so a tuning change and an offset change reach the phase output after different fixed latencies. A power-down input freezes the accumulator and forces the output phase to zero. When power-down is released, counting resumes from the held value.

Top module: `dds_phase_core`

## Requirements
- R1: While reset is asserted and immediately after it, `phase_out` is 0. The accumulator, the active tuning word and the active offset all reset to 0.
- R2: At each clock edge where `pwr_down` is low, the accumulator advances by the active tuning word, modulo 2^32. `phase_out` after edge n equals bits 31..18 of the accumulator as it stood before edge n plus the active offset shifted left by 27.
- R3: The offset is added at accumulator bits 31..27, so one offset step is 1/32 turn (11.25 degrees). With the accumulator at 0, an offset of 1 gives `phase_out` = 512 and an offset of 31 gives 15872.
- R4: An update event occurs at the first edge k that samples `upd_async` high after it was sampled low. Holding the strobe high for many cycles produces only one event.
- R5: A new tuning word first affects `phase_out` after edge k+18. It is first used in the accumulation at edge k+17.
- R6: A new offset first appears in `phase_out` after edge k+13.
- R7: Events spaced closer than the latencies are all applied, in order, each with its own latency.
- R8: `tune_word_in` and `phase_off_in` are sampled only at edge k+2 of an event. Changes at any other time have no effect on `phase_out`.
- R9: At any edge that samples `pwr_down` high, the accumulator holds its value and `phase_out` becomes 0.
- R10: After `pwr_down` falls, accumulation continues from the held value. The first phase output after release reflects the accumulator value from before power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_async | input | 1 | Update strobe from the control domain; its rising edge commits new values |
| tune_word_in | input | 32 | Frequency tuning word from the control register |
| phase_off_in | input | 5 | Phase offset from the control register, 11.25 degrees per step |
| pwr_down | input | 1 | Synchronous power-down: freezes the accumulator and zeroes the output |
| phase_out | output | 14 | Registered output phase for the sine lookup |

## Verification
The hardest situation to create is two updates in flight at the same time in both delay lines, with each result traced back to its own event. A related case is a strobe held high while the control inputs change after the capture edge. The bench produces both. It issues events a few cycles apart with distinct values. It also keeps the strobe high across a data change, so that a level-triggered capture or a wrong capture edge produces a visibly different phase. A reference model built from event timestamps checks every cycle. Directed checks use a zero tuning word and a frozen accumulator, so that the exact edge on which the offset and the tuning word take effect can be read straight from `phase_out`.

// File: rtl/dds_pkg.sv
`timescale 1ns/1ps
package dds_pkg;
    localparam int ACC_W_DEF  = 32;
    localparam int OFF_W_DEF  = 5;
    localparam int OUT_W_DEF  = 14;
    localparam int FREQ_LAT_DEF  = 18;
    localparam int PHASE_LAT_DEF = 13;

    // edges from the event edge until the control values are captured
    localparam int CAPTURE_EDGES = 2;

    typedef struct packed {
        logic meta;
        logic stable;
        logic prev;
    } sync_state_t;
endpackage

// File: rtl/dds_sync_edge.sv
`timescale 1ns/1ps
module dds_sync_edge
    import dds_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_pulse
);
    sync_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = async_in;
        st_d.stable = st_q.meta;
        st_d.prev   = st_q.stable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_pulse = st_q.stable & ~st_q.prev;

    // R4
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |=> !rise_pulse);
endmodule

// File: rtl/dds_delay_line.sv
`timescale 1ns/1ps
module dds_delay_line #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_data,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_data
);
    typedef struct packed {
        logic             valid;
        logic [WIDTH-1:0] data;
    } stage_t;

    stage_t [DEPTH-1:0] line_d, line_q;

    always_comb begin
        line_d          = line_q;
        line_d[0].valid = in_valid;
        line_d[0].data  = in_valid ? in_data : line_q[0].data;
        for (int i = 1; i < DEPTH; i++) begin
            line_d[i] = line_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_d;
    end

    assign out_valid = line_q[DEPTH-1].valid;
    assign out_data  = line_q[DEPTH-1].data;

    generate
        for (genvar g = 0; g + 1 < DEPTH; g++) begin : g_adv
            // R7
            stage_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
                line_q[g].valid |=> (line_q[g+1].valid && line_q[g+1].data == $past(line_q[g].data)));
        end
    endgenerate
endmodule

// File: rtl/dds_accum.sv
`timescale 1ns/1ps
module dds_accum #(
    parameter int ACC_W = 32,
    parameter int OFF_W = 5,
    parameter int OUT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_down,
    input  logic             ftw_ld_valid,
    input  logic [ACC_W-1:0] ftw_ld_data,
    input  logic             pow_ld_valid,
    input  logic [OFF_W-1:0] pow_ld_data,
    output logic [OUT_W-1:0] phase_out
);
    localparam int PAD_W = ACC_W - OFF_W;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [ACC_W-1:0] ftw_act;
        logic [OFF_W-1:0] pow_act;
        logic [OUT_W-1:0] phase;
    } acc_state_t;

    acc_state_t       s_d, s_q;
    logic [ACC_W-1:0] phase_sum;

    always_comb begin
        s_d       = s_q;
        phase_sum = s_q.acc + {s_q.pow_act, {PAD_W{1'b0}}};
        if (!pwr_down) s_d.acc = s_q.acc + s_q.ftw_act;
        s_d.phase = pwr_down ? '0 : phase_sum[ACC_W-1 -: OUT_W];
        if (ftw_ld_valid) s_d.ftw_act = ftw_ld_data;
        if (pow_ld_valid) s_d.pow_act = pow_ld_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign phase_out = s_q.phase;

    // R9
    pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> $stable(s_q.acc));
    // R9
    pd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> (phase_out == '0));
    // R8
    ftw_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ftw_ld_valid |=> $stable(s_q.ftw_act));
    // R8
    pow_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pow_ld_valid |=> $stable(s_q.pow_act));
    // R2
    acc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_down |=> (s_q.acc == $past(s_q.acc) + $past(s_q.ftw_act)));
endmodule

// File: rtl/dds_phase_core.sv
`timescale 1ns/1ps
module dds_phase_core
    import dds_pkg::*;
#(
    parameter int ACC_W     = ACC_W_DEF,
    parameter int OFF_W     = OFF_W_DEF,
    parameter int OUT_W     = OUT_W_DEF,
    parameter int FREQ_LAT  = FREQ_LAT_DEF,
    parameter int PHASE_LAT = PHASE_LAT_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_async,
    input  logic [ACC_W-1:0] tune_word_in,
    input  logic [OFF_W-1:0] phase_off_in,
    input  logic             pwr_down,
    output logic [OUT_W-1:0] phase_out
);
    // A tuning word also passes through its active register and the accumulator.
    // An offset passes only through its active register before the output register.
    localparam int FREQ_DEPTH  = FREQ_LAT  - CAPTURE_EDGES - 2;
    localparam int PHASE_DEPTH = PHASE_LAT - CAPTURE_EDGES - 1;

    logic             upd_pulse;
    logic             ftw_valid, pow_valid;
    logic [ACC_W-1:0] ftw_data;
    logic [OFF_W-1:0] pow_data;

    dds_sync_edge sync_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_in   (upd_async),
        .rise_pulse (upd_pulse)
    );

    dds_delay_line #(.WIDTH(ACC_W), .DEPTH(FREQ_DEPTH)) freq_line_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (upd_pulse),
        .in_data   (tune_word_in),
        .out_valid (ftw_valid),
        .out_data  (ftw_data)
    );

    dds_delay_line #(.WIDTH(OFF_W), .DEPTH(PHASE_DEPTH)) phase_line_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (upd_pulse),
        .in_data   (phase_off_in),
        .out_valid (pow_valid),
        .out_data  (pow_data)
    );

    dds_accum #(.ACC_W(ACC_W), .OFF_W(OFF_W), .OUT_W(OUT_W)) accum_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwr_down     (pwr_down),
        .ftw_ld_valid (ftw_valid),
        .ftw_ld_data  (ftw_data),
        .pow_ld_valid (pow_valid),
        .pow_ld_data  (pow_data),
        .phase_out    (phase_out)
    );

    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (phase_out == '0));
endmodule

// File: tb/dds_phase_core_tb.sv
`timescale 1ns/1ps
module dds_phase_core_tb_top;
    localparam int FREQ_LAT  = 18;
    localparam int PHASE_LAT = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd = 1'b0;
    logic [31:0] tune = '0;
    logic [4:0]  off = '0;
    logic        pd = 1'b0;
    logic [13:0] phase_out;

    int checks = 0;
    int failures = 0;
    int edge_n = 0;
    bit finished = 1'b0;
    string cur_req = "R1";

    // model state
    logic [31:0] m_acc = '0, m_ftw = '0;
    logic [4:0]  m_pow = '0;
    logic [13:0] m_out = '0;
    logic        m_upd_prev = 1'b0;
    int          cap_t[$];
    int          ftw_t[$];
    logic [31:0] ftw_v[$];
    int          pow_t[$];
    logic [4:0]  pow_v[$];

    always #5 clk = ~clk;

    dds_phase_core dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .upd_async    (upd),
        .tune_word_in (tune),
        .phase_off_in (off),
        .pwr_down     (pd),
        .phase_out    (phase_out)
    );

    task automatic check(input string req, input logic [13:0] act, input logic [13:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s phase_out=%0d expected=%0d at edge %0d", req, act, exp, edge_n);
        end
    endtask

    task automatic step();
        logic [31:0] sum;
        logic [31:0] nacc;
        logic [13:0] nout;
        @(posedge clk);
        if (upd && !m_upd_prev) cap_t.push_back(edge_n + 2);
        m_upd_prev = upd;
        sum  = m_acc + {m_pow, 27'b0};
        nacc = pd ? m_acc : m_acc + m_ftw;
        nout = pd ? 14'd0 : sum[31:18];
        m_acc = nacc;
        m_out = nout;
        if (ftw_t.size() > 0 && ftw_t[0] == edge_n) begin
            m_ftw = ftw_v.pop_front();
            void'(ftw_t.pop_front());
        end
        if (pow_t.size() > 0 && pow_t[0] == edge_n) begin
            m_pow = pow_v.pop_front();
            void'(pow_t.pop_front());
        end
        if (cap_t.size() > 0 && cap_t[0] == edge_n) begin
            void'(cap_t.pop_front());
            ftw_t.push_back(edge_n - 2 + FREQ_LAT - 2);
            ftw_v.push_back(tune);
            pow_t.push_back(edge_n - 2 + PHASE_LAT - 1);
            pow_v.push_back(off);
        end
        edge_n++;
        @(negedge clk);
        check(cur_req, phase_out, m_out);
    endtask

    // step until edge 'last' has completed
    task automatic run_to(input int last);
        while (edge_n <= last) step();
    endtask

    task automatic event_upd(input logic [31:0] t, input logic [4:0] o, output int k);
        tune = t;
        off  = o;
        upd  = 1'b1;
        k    = edge_n;
        repeat (3) step();
        upd = 1'b0;
        step();
    endtask

    initial begin
        int k, k2, v;
        logic [13:0] prev;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", phase_out, 14'd0);
        rst_n = 1'b1;
        check("R1", phase_out, 14'd0);
        repeat (4) step();
        check("R1", phase_out, 14'd0);

        // R6 / R3: offset 1 with a still accumulator
        cur_req = "R6";
        event_upd(32'd0, 5'd1, k);
        run_to(k + 12);
        check("R6", phase_out, 14'd0);
        run_to(k + 13);
        check("R6", phase_out, 14'd512);
        run_to(k + 20);
        check("R3", phase_out, 14'd512);

        cur_req = "R3";
        event_upd(32'd0, 5'd31, k);
        run_to(k + 13);
        check("R3", phase_out, 14'd15872);

        // R5: tuning word one output LSB per clock, offset back to 0
        cur_req = "R5";
        event_upd(32'h0004_0000, 5'd0, k);
        run_to(k + 17);
        check("R5", phase_out, 14'd0);
        run_to(k + 18);
        check("R5", phase_out, 14'd1);
        run_to(k + 19);
        check("R5", phase_out, 14'd2);

        // R8: inputs change with no event
        cur_req = "R8";
        run_to(k + 30);
        prev = phase_out;
        for (int i = 0; i < 30; i++) begin
            tune = $urandom();
            off  = 5'($urandom());
            step();
            check("R8", phase_out, prev + 14'd1);
            prev = phase_out;
        end

        // R9 / R10: power-down and resume
        cur_req = "R9";
        v  = int'(phase_out);
        pd = 1'b1;
        repeat (5) begin
            step();
            check("R9", phase_out, 14'd0);
        end
        pd = 1'b0;
        cur_req = "R10";
        step();
        check("R10", phase_out, 14'(v + 1));
        step();
        check("R10", phase_out, 14'(v + 2));

        // R4 / R8: strobe held high, data changed after capture edge
        cur_req = "R4";
        tune = 32'd0;
        off  = 5'd8;
        upd  = 1'b1;
        k    = edge_n;
        repeat (3) step();
        tune = 32'h0000_0000;
        off  = 5'd20;
        repeat (12) step();
        upd = 1'b0;
        run_to(k + 40);
        check("R4", phase_out, m_out);

        // R7: overlapping events
        cur_req = "R7";
        event_upd(32'h0E38_E38E, 5'd2, k);
        step();
        event_upd(32'h0100_0000, 5'd7, k2);
        run_to(k2 + 30);

        // R2: random mix
        cur_req = "R2";
        for (int i = 0; i < 120; i++) begin
            pd = ($urandom_range(0, 7) == 0);
            event_upd($urandom(), 5'($urandom()), k);
            repeat ($urandom_range(0, 12)) begin
                pd = ($urandom_range(0, 9) == 0);
                step();
            end
        end
        pd = 1'b0;
        repeat (40) step();

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule